// File: doc/BRIEF.md
# Wake-on-Change General-Purpose I/O Port

This block is the eight-bit general-purpose I/O port of a small microcontroller with a 12-bit instruction core. It holds the output data latches and the direction register, drives the pin output enables and levels, turns the weak pull-ups on or off from an option bit, and returns a read value that mixes pin levels and latch contents. The core, its timer and its instruction decoder are outside the block; the core reaches the port through a data write strobe, a direction-load strobe carrying the accumulator value, and two option bits.

While the core sleeps, the port watches a fixed group of input pins. All pin levels pass through a two-flop synchronizer, and a change on a watched pin, against the value sampled one clock earlier, raises a one-cycle wake request. That request is treated as an I/O-type reset: it returns the direction register to its reset value and sets a sticky wake flag that the core shows as bit 7 of its status register. The flag is cleared when the core enters sleep. The default configuration is the variant with an internal serial-memory link on bits 6 and 7, which are always outputs and whose latches reset high.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset the direction register is 0x3F, so pin_oe is 0xC0 (only the two link bits 6 and 7 drive), pin_out is 0xC0, wake_req and wake_flag are 0, and with all pins low rd_data is 0xC0.
- R2: A dir_load stores acc_val masked with 0x3F; on the next clock pin_oe equals ((~acc_val) & 0x37) | 0xC0: bit 3 is input-only and never drives, bits 6 and 7 always drive, and a 0 direction bit drives pins 0, 1, 2, 4, 5.
- R3: A data_wr stores data_in into the latch, shown on pin_out after the same clock edge; rd_data, registered, returns for each bit the synchronized pin level when the bit is an input (direction bit 1, or bit 3) and the latch value when it is an output, so a pin change reaches rd_data on the third rising edge after it.
- R4: pu_en equals 0xC3 (pull-up capable pins 0, 1, 6, 7) one clock after pu_off is 0, and 0x00 one clock after pu_off is 1.
- R5: A level change on pin 0, 1 or 3 while sleeping is 1 and wake_off is 0 produces exactly one wake_req pulse, one clock wide, on the third rising edge after the change; a held level produces no further pulse.
- R6: wake_flag is set in the same clock as a wake_req pulse and stays set until sleep_enter; sleep_enter clears it on the next clock, except that a wake in that same clock wins and keeps it set.
- R7: A wake returns the direction register to 0x3F in the same clock as the pulse (pin_oe becomes 0xC0) and leaves the output latch unchanged.
- R8: Changes on pins 2, 4, 5, 6 or 7, changes while sleeping is 0, and changes while wake_off is 1 produce no wake_req pulse and leave wake_flag and pin_oe unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_in | input | 8 | Asynchronous pin levels |
| data_wr | input | 1 | Output latch write strobe |
| data_in | input | 8 | Output latch write data |
| dir_load | input | 1 | Direction register load strobe |
| acc_val | input | 8 | Accumulator value carried by the direction load |
| pu_off | input | 1 | Option bit 6: 1 disables weak pull-ups |
| wake_off | input | 1 | Option bit 7: 1 disables wake-on-change |
| sleeping | input | 1 | Core is asleep |
| sleep_enter | input | 1 | One-cycle strobe when the core enters sleep |
| rd_data | output | 8 | Registered port read value |
| pin_oe | output | 8 | Registered per-pin output enable |
| pin_out | output | 8 | Registered per-pin output level (latch) |
| pu_en | output | 8 | Registered per-pin weak pull-up enable |
| wake_req | output | 1 | One-cycle wake request pulse |
| wake_flag | output | 1 | Sticky wake flag, status bit 7 |

## Verification
The assertions assume the core's strobes are clean single-clock levels sampled on the rising edge and that pin_in may change at any time but is only ever seen through the synchronizer; the bench drives every input on the falling edge, so no strobe or pin change races the sampling edge. They also assume sleep_enter is a one-clock strobe and that a direction load is allowed in the same clock as a wake, with the wake taking precedence; the stimulus exercises that coincidence only for sleep_enter, where the flag's priority is checked directly.

// File: rtl/gwk_pkg.sv
package gwk_pkg;
  localparam int PORT_W = 8;
  typedef logic [PORT_W-1:0] port_t;

  // read value: inputs show the synchronized pin, outputs the latch
  function automatic port_t read_mux(port_t pins, port_t latch, port_t dir,
                                     port_t en_mask, port_t in_only);
    port_t r;
    for (int b = 0; b < PORT_W; b++) begin
      if (!en_mask[b])                 r[b] = 1'b0;
      else if (dir[b] || in_only[b])   r[b] = pins[b];
      else                             r[b] = latch[b];
    end
    return r;
  endfunction
endpackage

// File: rtl/gwk_sync.sv
module gwk_sync
  import gwk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  port_t d,
  output port_t q
);
  port_t chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gwk_change_det.sv
module gwk_change_det
  import gwk_pkg::*;
#(
  parameter port_t WATCH_MASK = 8'h0B
) (
  input  logic  clk,
  input  logic  rst,
  input  port_t pins_s,
  input  logic  sleeping_i,
  input  logic  wake_off_i,
  output logic  wake_hit,
  output logic  wake_req_o
);
  port_t ref_q;
  logic  changed;

  // reference follows the sampled pins every clock, so a held level is quiet
  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else     ref_q <= pins_s;
  end

  assign changed  = |((pins_s ^ ref_q) & WATCH_MASK);
  assign wake_hit = changed && sleeping_i && !wake_off_i;

  always_ff @(posedge clk) begin
    if (rst) wake_req_o <= 1'b0;
    else     wake_req_o <= wake_hit;
  end

  // R5 / R8: a pulse only follows a clock where the core slept with wakes enabled
  assert_wake_gate_R5: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> ($past(sleeping_i) && !$past(wake_off_i)));

  // R8: no pulse when nothing watched moved in the previous clock
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !changed |=> !wake_req_o);
endmodule

// File: rtl/gwk_port_regs.sv
module gwk_port_regs
  import gwk_pkg::*;
#(
  parameter port_t EN_MASK    = 8'hFF,
  parameter port_t IN_ONLY    = 8'h08,
  parameter port_t FORCED_OUT = 8'hC0,
  parameter port_t PU_CAP     = 8'hC3,
  parameter port_t DIR_RST    = 8'h3F,
  parameter port_t LAT_RST    = 8'hC0
) (
  input  logic  clk,
  input  logic  rst,
  input  port_t pins_s,
  input  logic  data_wr,
  input  port_t data_in,
  input  logic  dir_load,
  input  port_t acc_val,
  input  logic  pu_off,
  input  logic  wake_i,
  output port_t rd_data,
  output port_t pin_oe,
  output port_t pin_out,
  output port_t pu_en
);
  localparam port_t DIR_MASK = ~FORCED_OUT;
  localparam port_t DRV_MASK = EN_MASK & ~IN_ONLY;
  localparam port_t RST_OE   = ((~DIR_RST & DRV_MASK) | FORCED_OUT) & EN_MASK;

  port_t dir_q, dir_n, lat_n, oe_n;

  always_comb begin
    if (wake_i)        dir_n = DIR_RST;
    else if (dir_load) dir_n = acc_val & DIR_MASK;
    else               dir_n = dir_q;
    lat_n = data_wr ? (data_in & EN_MASK) : pin_out;
    oe_n  = ((~dir_n & DRV_MASK) | FORCED_OUT) & EN_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_RST;
      pin_out <= LAT_RST & EN_MASK;
      pin_oe  <= RST_OE;
      pu_en   <= '0;
      rd_data <= '0;
    end else begin
      dir_q   <= dir_n;
      pin_out <= lat_n;
      pin_oe  <= oe_n;
      pu_en   <= pu_off ? '0 : (EN_MASK & PU_CAP);
      rd_data <= read_mux(pins_s, pin_out, dir_q, EN_MASK, IN_ONLY);
    end
  end

  // R2: the forced link bits drive and the input-only pin never does
  always @(posedge clk) begin
    if (!rst) begin
      assert_forced_oe_R2: assert (((pin_oe & FORCED_OUT & EN_MASK) == (FORCED_OUT & EN_MASK))
                                   && ((pin_oe & IN_ONLY) == '0));
    end
  end

  // R7: a wake leaves the port with the reset direction
  assert_wake_dir_R7: assert property (@(posedge clk) disable iff (rst)
    wake_i |=> (pin_oe == RST_OE));

  // R7 / R3: the latch moves only on a write
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> $stable(pin_out));

  // R4: pull-ups off one clock after the option disables them
  assert_pu_off_R4: assert property (@(posedge clk) disable iff (rst)
    pu_off |=> (pu_en == '0));
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gwk_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter bit    LINK_VARIANT = 1'b1,
  parameter port_t PHYS_MASK  = 8'h3F,
  parameter port_t WATCH_MASK = 8'h0B,
  parameter port_t IN_ONLY    = 8'h08,
  parameter port_t PU_PHYS    = 8'h03,
  parameter port_t DIR_RST    = 8'h3F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pin_in,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  input  logic       dir_load,
  input  logic [7:0] acc_val,
  input  logic       pu_off,
  input  logic       wake_off,
  input  logic       sleeping,
  input  logic       sleep_enter,
  output logic [7:0] rd_data,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic [7:0] pu_en,
  output logic       wake_req,
  output logic       wake_flag
);
  localparam port_t LINK_BITS  = LINK_VARIANT ? ~PHYS_MASK : '0;
  localparam port_t EN_MASK    = PHYS_MASK | LINK_BITS;
  localparam port_t PU_CAP     = PU_PHYS | LINK_BITS;
  localparam port_t LAT_RST    = LINK_BITS;

  port_t pins_s;
  logic  wake_hit;

  gwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (pin_in), .q (pins_s)
  );

  gwk_change_det #(.WATCH_MASK(WATCH_MASK)) u_det (
    .clk        (clk),
    .rst        (rst),
    .pins_s     (pins_s),
    .sleeping_i (sleeping),
    .wake_off_i (wake_off),
    .wake_hit   (wake_hit),
    .wake_req_o (wake_req)
  );

  gwk_port_regs #(
    .EN_MASK    (EN_MASK),
    .IN_ONLY    (IN_ONLY),
    .FORCED_OUT (LINK_BITS),
    .PU_CAP     (PU_CAP),
    .DIR_RST    (DIR_RST & ~LINK_BITS),
    .LAT_RST    (LAT_RST)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .pins_s   (pins_s),
    .data_wr  (data_wr),
    .data_in  (data_in),
    .dir_load (dir_load),
    .acc_val  (acc_val),
    .pu_off   (pu_off),
    .wake_i   (wake_hit),
    .rd_data  (rd_data),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .pu_en    (pu_en)
  );

  // sticky wake flag: a wake outranks the sleep-entry clear
  always_ff @(posedge clk) begin
    if (rst)              wake_flag <= 1'b0;
    else if (wake_hit)    wake_flag <= 1'b1;
    else if (sleep_enter) wake_flag <= 1'b0;
  end

  // R6: the flag only rises together with a wake pulse
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> wake_req);

  // R6: sleep entry clears the flag unless a wake lands in the same clock
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    sleep_enter |=> (!wake_flag || wake_req));
endmodule

// File: tb/gpio_wake_port_tb.sv
module gpio_wake_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pin_in, data_in, acc_val;
  logic       data_wr, dir_load, pu_off, wake_off, sleeping, sleep_enter;
  logic [7:0] rd_data, pin_oe, pin_out, pu_en;
  logic       wake_req, wake_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wake_port u_dut (
    .clk (clk), .rst (rst), .pin_in (pin_in), .data_wr (data_wr),
    .data_in (data_in), .dir_load (dir_load), .acc_val (acc_val),
    .pu_off (pu_off), .wake_off (wake_off), .sleeping (sleeping),
    .sleep_enter (sleep_enter), .rd_data (rd_data), .pin_oe (pin_oe),
    .pin_out (pin_out), .pu_en (pu_en), .wake_req (wake_req),
    .wake_flag (wake_flag)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic load_dir(logic [7:0] v);
    dir_load = 1'b1; acc_val = v; tick(); dir_load = 1'b0;
  endtask

  task automatic write_lat(logic [7:0] v);
    data_wr = 1'b1; data_in = v; tick(); data_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin_in = '0; data_in = '0; acc_val = '0;
    data_wr = 0; dir_load = 0; pu_off = 1; wake_off = 0;
    sleeping = 0; sleep_enter = 0;
    repeat (3) tick();
    rst = 1'b0;
    repeat (3) tick();

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'hC0);
    check("R1 pin_out", pin_out, 8'hC0);
    check("R1 wake_req", wake_req, 0);
    check("R1 wake_flag", wake_flag, 0);
    check("R1 rd_data", rd_data, 8'hC0);

    // R2 direction load sweep
    for (int v = 0; v < 256; v++) begin
      load_dir(8'(v));
      check("R2 pin_oe", pin_oe, ((~v) & 8'h37) | 8'hC0);
    end

    // R3 latch sweep with every physical output enabled, pins low
    load_dir(8'h00);
    for (int v = 0; v < 256; v++) begin
      write_lat(8'(v));
      check("R3 pin_out", pin_out, v);
      tick();
      check("R3 rd_data latch", rd_data, v & 8'hF7);
    end

    // R3 pin read sweep with physical pins as inputs, link latches low
    load_dir(8'h3F);
    write_lat(8'h00);
    for (int p = 0; p < 256; p++) begin
      pin_in = 8'(p);
      repeat (3) tick();
      check("R3 rd_data pins", rd_data, p & 8'h3F);
    end
    pin_in = '0;
    repeat (4) tick();

    // R4 pull-ups
    pu_off = 1'b0; tick();
    check("R4 pu on", pu_en, 8'hC3);
    pu_off = 1'b1; tick();
    check("R4 pu off", pu_en, 8'h00);

    // R5 R6 R7 R8 wake sweep over pin and mode
    for (int b = 0; b < 8; b++) begin
      for (int m = 0; m < 4; m++) begin
        int cnt;
        bit exp;
        exp = ((8'h0B >> b) & 1) && (m[0] == 1'b1) && (m[1] == 1'b0);
        sleeping = 1'b0; pin_in = '0;
        repeat (4) tick();
        load_dir(8'h00);
        write_lat(8'h5A);
        sleeping = m[0]; wake_off = m[1];
        sleep_enter = 1'b1; tick(); sleep_enter = 1'b0;
        check("R6 flag cleared by sleep", wake_flag, 0);
        pin_in = 8'(1 << b);
        cnt = 0;
        for (int t = 0; t < 8; t++) begin
          tick();
          cnt += int'(wake_req);
        end
        if (exp) check("R5 one wake pulse", cnt, 1);
        else     check("R8 no wake pulse", cnt, 0);
        check("R6 flag after change", wake_flag, int'(exp));
        check("R7 direction after change", pin_oe, exp ? 8'hC0 : 8'hF7);
        check("R7 latch kept", pin_out, 8'h5A);
      end
    end

    // R6 wake and sleep entry in the same clock: wake wins
    sleeping = 1'b0; wake_off = 1'b0; pin_in = '0;
    repeat (4) tick();
    sleeping = 1'b1;
    sleep_enter = 1'b1; tick(); sleep_enter = 1'b0;
    pin_in = 8'h01;
    tick(); tick();
    sleep_enter = 1'b1; tick(); sleep_enter = 1'b0;
    check("R6 wake pulse with sleep entry", wake_req, 1);
    check("R6 set wins over clear", wake_flag, 1);
    tick();
    check("R5 single cycle pulse", wake_req, 0);
    sleep_enter = 1'b1; tick(); sleep_enter = 1'b0;
    check("R6 later sleep entry clears", wake_flag, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule